// File: doc/BRIEF.md
# DMA Channel Control and Status Register

This block is the single 32-bit control and status word of one DMA channel. Software writes it to start the channel, to ask a running channel to stop or halt, to choose chained operation and the bus tenure settings, and to arm or mask interrupt sources. The descriptor walker next to it receives one-cycle start, stop and halt strobes. It returns one-cycle event pulses for completion, stop, halt and three error kinds.

Each event pulse sets a sticky status bit. A status bit is cleared by writing a one to it. Software normally clears all old status in the same write that sets the start bit. The channel shows itself busy from the start until the walker reports that it has finished or aborted. After that, the status and configuration read back unchanged until the next start. A level interrupt is raised while any latched event has its enable set.

Top module: `dma_gcsr`

## Requirements
- R1: After reset, rd_data reads all zero, and irq, start_stb, stop_stb and halt_stb are low.
- R2: A write with bit 31 set while the active bit (bit 15) is clear gives start_stb high for exactly the one cycle after the write and sets active. A write with bit 31 set while active is already set is ignored and gives no start_stb.
- R3: Bits 31, 30 and 29 always read as zero. Bits 28, 23, 12, 7 and 4 are also zero.
- R4: A write with bit 30 set while active gives one stop_stb pulse. A write with bit 29 set while active gives one halt_stb pulse. If a walker event ends the channel in that same cycle, or the channel is idle, the write produces no pulse.
- R5: The chain enable (bit 27), tenure length (bits 22:20) and tenure gap (bits 19:16) load only from writes made while idle. They drive chain_en, tenure_len and tenure_gap. A write made while active leaves them unchanged.
- R6: In the cycle after any walker event pulse, the active bit is clear.
- R7: Each event pulse sets a sticky status bit: stopped at bit 14, halted at bit 13, done at bit 11, local-bus error at bit 10, backplane error at bit 9 and parity error at bit 8. Writing a one to a status bit clears it. If an event and its clear arrive in the same cycle, the event wins.
- R8: The interrupt enables sit at bit 6 (stopped), bit 5 (halted), bit 3 (done), bit 2 (local error), bit 1 (backplane error) and bit 0 (parity error). Every write loads them, whether the channel is idle or active.
- R9: irq is high exactly when some status bit and its enable are both set.
- R10: A single write with bit 31 set and ones in the status bits clears that status and starts the channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Register read value |
| irq | output | 1 | Level interrupt |
| start_stb | output | 1 | Start strobe to walker |
| stop_stb | output | 1 | Stop request strobe to walker |
| halt_stb | output | 1 | Halt request strobe to walker |
| chain_en | output | 1 | Chained mode setting |
| tenure_len | output | 3 | Bus tenure length code |
| tenure_gap | output | 4 | Gap between tenures code |
| ev_done | input | 1 | Walker: chain completed |
| ev_stopped | input | 1 | Walker: stopped on request |
| ev_halted | input | 1 | Walker: halted on request |
| ev_lerr | input | 1 | Walker: local-bus error |
| ev_verr | input | 1 | Walker: backplane error |
| ev_perr | input | 1 | Walker: parity error |

## Verification
Directed sequences cover the following cases:
- A start that clears old status in the same write, which separates W1C from start handling.
- A second start while busy.
- Configuration and stop writes against an idle channel, which show the idle and active gating.
- An event that coincides with its own clear, which shows the set-over-clear priority.

Random traffic then mixes writes of random data with random single event pulses, in both idle and active phases. This exercises enable masking, the start and abort interplay, and the interrupt under many status and enable combinations.

// File: rtl/dgcsr_pkg.sv
package dgcsr_pkg;
  localparam int NUM_EV    = 6;
  localparam int LEN_W     = 3;
  localparam int GAP_W     = 4;
  localparam int GO_BIT    = 31;
  localparam int STOP_BIT  = 30;
  localparam int HALT_BIT  = 29;
  localparam int CHAIN_BIT = 27;
  localparam int LEN_LSB   = 20;
  localparam int GAP_LSB   = 16;
  localparam int ACT_BIT   = 15;
  localparam int STAT_BASE = 8;

  // event index: 0 parity, 1 backplane, 2 local, 3 done, 4 halted, 5 stopped
  function automatic int ev_slot(input int idx);
    return (idx < 4) ? idx : idx + 1;
  endfunction

  typedef struct packed {
    logic             chain;
    logic [LEN_W-1:0] len;
    logic [GAP_W-1:0] gap;
  } dgc_cfg_t;
endpackage

// File: rtl/dgcsr_rst_sync.sv
module dgcsr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/dgcsr_cfg.sv
module dgcsr_cfg
  import dgcsr_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     load,
  input  dgc_cfg_t cfg_in,
  output dgc_cfg_t cfg
);
  dgc_cfg_t cfg_q, cfg_d;

  always_comb begin
    cfg_d = load ? cfg_in : cfg_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cfg_q <= '0;
    else if (load) cfg_q <= cfg_d;
  end

  assign cfg = cfg_q;
endmodule

// File: rtl/dgcsr_evt.sv
module dgcsr_evt #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  input  logic         en_wr,
  input  logic [N-1:0] en_din,
  output logic [N-1:0] status,
  output logic [N-1:0] enable,
  output logic         irq
);
  logic [N-1:0] status_q, status_d;
  logic [N-1:0] enable_q, enable_d;

  always_comb begin
    status_d = (status_q & ~clr) | set;
    enable_d = en_wr ? en_din : enable_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      enable_q <= '0;
    end else begin
      status_q <= status_d;
      if (en_wr) enable_q <= enable_d;
    end
  end

  assign status = status_q;
  assign enable = enable_q;
  assign irq    = |(status_q & enable_q);
endmodule

// File: rtl/dgcsr_seq.sv
module dgcsr_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic go_req,
  input  logic stop_req,
  input  logic halt_req,
  input  logic finish,
  output logic active,
  output logic start_stb,
  output logic stop_stb,
  output logic halt_stb
);
  typedef enum logic {ST_IDLE, ST_RUN} seq_state_t;
  seq_state_t state_q, state_d;
  logic start_d, stop_d, halt_d;
  logic start_q, stop_q, halt_q;

  always_comb begin
    state_d = state_q;
    start_d = 1'b0;
    stop_d  = 1'b0;
    halt_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (go_req) begin
          state_d = ST_RUN;
          start_d = 1'b1;
        end
      end
      ST_RUN: begin
        if (finish) begin
          state_d = ST_IDLE;
        end else begin
          stop_d = stop_req;
          halt_d = halt_req;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      start_q <= 1'b0;
      stop_q  <= 1'b0;
      halt_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      start_q <= start_d;
      stop_q  <= stop_d;
      halt_q  <= halt_d;
    end
  end

  assign active    = (state_q == ST_RUN);
  assign start_stb = start_q;
  assign stop_stb  = stop_q;
  assign halt_stb  = halt_q;
endmodule

// File: rtl/dma_gcsr.sv
module dma_gcsr
  import dgcsr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [31:0]      wr_data,
  output logic [31:0]      rd_data,
  output logic             irq,
  output logic             start_stb,
  output logic             stop_stb,
  output logic             halt_stb,
  output logic             chain_en,
  output logic [LEN_W-1:0] tenure_len,
  output logic [GAP_W-1:0] tenure_gap,
  input  logic             ev_done,
  input  logic             ev_stopped,
  input  logic             ev_halted,
  input  logic             ev_lerr,
  input  logic             ev_verr,
  input  logic             ev_perr
);
  logic              rst_i_n;
  logic              active;
  logic [NUM_EV-1:0] ev_vec, clr_vec, en_din, status, enable;
  dgc_cfg_t          cfg_in, cfg;

  dgcsr_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n)
  );

  assign ev_vec = {ev_stopped, ev_halted, ev_done, ev_lerr, ev_verr, ev_perr};

  for (genvar g = 0; g < NUM_EV; g++) begin : g_dec
    assign clr_vec[g] = wr_en & wr_data[STAT_BASE + ev_slot(g)];
    assign en_din[g]  = wr_data[ev_slot(g)];
  end

  assign cfg_in.chain = wr_data[CHAIN_BIT];
  assign cfg_in.len   = wr_data[LEN_LSB +: LEN_W];
  assign cfg_in.gap   = wr_data[GAP_LSB +: GAP_W];

  dgcsr_seq u_seq (
    .clk(clk), .rst_n(rst_i_n),
    .go_req(wr_en & wr_data[GO_BIT]),
    .stop_req(wr_en & wr_data[STOP_BIT]),
    .halt_req(wr_en & wr_data[HALT_BIT]),
    .finish(|ev_vec),
    .active(active),
    .start_stb(start_stb), .stop_stb(stop_stb), .halt_stb(halt_stb)
  );

  dgcsr_cfg u_cfg (
    .clk(clk), .rst_n(rst_i_n),
    .load(wr_en & ~active),
    .cfg_in(cfg_in), .cfg(cfg)
  );

  dgcsr_evt #(.N(NUM_EV)) u_evt (
    .clk(clk), .rst_n(rst_i_n),
    .set(ev_vec), .clr(clr_vec),
    .en_wr(wr_en), .en_din(en_din),
    .status(status), .enable(enable), .irq(irq)
  );

  always_comb begin
    rd_data = '0;
    rd_data[CHAIN_BIT] = cfg.chain;
    rd_data[LEN_LSB +: LEN_W] = cfg.len;
    rd_data[GAP_LSB +: GAP_W] = cfg.gap;
    rd_data[ACT_BIT] = active;
    for (int i = 0; i < NUM_EV; i++) begin
      rd_data[STAT_BASE + ev_slot(i)] = status[i];
      rd_data[ev_slot(i)]             = enable[i];
    end
  end

  assign chain_en   = cfg.chain;
  assign tenure_len = cfg.len;
  assign tenure_gap = cfg.gap;
endmodule

// File: rtl/dgcsr_chk.sv
module dgcsr_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       clr_done,
  input logic       active,
  input logic       done_st,
  input logic       irq,
  input logic       start_stb,
  input logic       stop_stb,
  input logic       halt_stb,
  input logic [7:0] cfg_bits,
  input logic [5:0] evt
);
  assert_start_from_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_stb |-> (active && !$past(active)));

  assert_start_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_stb |=> !start_stb);

  assert_abort_only_active_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_stb || halt_stb) |-> $past(active));

  assert_cfg_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active)) |-> $stable(cfg_bits));

  assert_active_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active) |-> $past(|evt));

  assert_done_w1c_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(done_st) |-> $past(wr_en && clr_done));

  assert_irq_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(wr_en || (|evt)));
endmodule

bind dma_gcsr dgcsr_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .clr_done(wr_data[11]),
  .active(rd_data[15]), .done_st(rd_data[11]), .irq(irq),
  .start_stb(start_stb), .stop_stb(stop_stb), .halt_stb(halt_stb),
  .cfg_bits({chain_en, tenure_len, tenure_gap}),
  .evt({ev_stopped, ev_halted, ev_done, ev_lerr, ev_verr, ev_perr})
);

// File: tb/dma_gcsr_test.sv
module dma_gcsr_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic        irq, start_stb, stop_stb, halt_stb, chain_en;
  logic [2:0]  tenure_len;
  logic [3:0]  tenure_gap;
  logic [5:0]  ev; // 0 perr,1 verr,2 lerr,3 done,4 halted,5 stopped

  int checks = 0;
  int fails  = 0;

  // model state
  logic       m_act, m_chain;
  logic [2:0] m_len;
  logic [3:0] m_gap;
  logic [5:0] m_stat, m_en;
  logic       m_start, m_stop, m_halt;

  always #2 clk = ~clk;

  dma_gcsr uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .irq(irq), .start_stb(start_stb),
    .stop_stb(stop_stb), .halt_stb(halt_stb), .chain_en(chain_en),
    .tenure_len(tenure_len), .tenure_gap(tenure_gap),
    .ev_done(ev[3]), .ev_stopped(ev[5]), .ev_halted(ev[4]),
    .ev_lerr(ev[2]), .ev_verr(ev[1]), .ev_perr(ev[0])
  );

  function automatic int slot(input int i);
    return (i < 4) ? i : i + 1;
  endfunction

  function automatic logic [5:0] stat_of(input logic [31:0] v);
    logic [5:0] r;
    for (int i = 0; i < 6; i++) r[i] = v[8 + slot(i)];
    return r;
  endfunction

  function automatic logic [5:0] en_of(input logic [31:0] v);
    logic [5:0] r;
    for (int i = 0; i < 6; i++) r[i] = v[slot(i)];
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R2 start_stb", {31'b0, start_stb}, {31'b0, m_start});
    chk("R4 stop/halt strobes", {30'b0, stop_stb, halt_stb}, {30'b0, m_stop, m_halt});
    chk("R3 zero bits", {rd_data[31:28], rd_data[23], rd_data[12], rd_data[7], rd_data[4]}, 32'd0);
    chk("R5 config", {rd_data[27], rd_data[22:16], chain_en, tenure_len, tenure_gap},
        {m_chain, m_len, m_gap, m_chain, m_len, m_gap});
    chk("R6 active", {31'b0, rd_data[15]}, {31'b0, m_act});
    chk("R7 status", {26'b0, stat_of(rd_data)}, {26'b0, m_stat});
    chk("R8 enables", {26'b0, en_of(rd_data)}, {26'b0, m_en});
    chk("R9 irq", {31'b0, irq}, {31'b0, |(m_stat & m_en)});
  endtask

  task automatic step(input logic w, input logic [31:0] d, input logic [5:0] e);
    logic fin;
    @(negedge clk);
    wr_en = w; wr_data = d; ev = e;
    fin = |e;
    m_start = w & d[31] & ~m_act;
    m_stop  = w & d[30] & m_act & ~fin;
    m_halt  = w & d[29] & m_act & ~fin;
    if (w && !m_act) begin
      m_chain = d[27]; m_len = d[22:20]; m_gap = d[19:16];
    end
    if (w) m_en = en_of(d);
    m_stat = (m_stat & ~(w ? stat_of(d) : 6'b0)) | e;
    m_act  = m_start | (m_act & ~fin);
    @(posedge clk);
    #1;
    compare_all();
  endtask

  initial begin : watchdog
    #400000;
    fails++;
    $display("FAIL watchdog expired");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    logic [31:0] d;
    logic [5:0]  e;
    void'($urandom(1234));
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; ev = '0;
    m_act = 0; m_chain = 0; m_len = 0; m_gap = 0; m_stat = 0; m_en = 0;
    m_start = 0; m_stop = 0; m_halt = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 reset rd_data", rd_data, 32'd0);
    chk("R1 reset outputs", {28'b0, irq, start_stb, stop_stb, halt_stb}, 32'd0);

    // stop/halt while idle ignored (R4); config loads idle (R5)
    step(1, 32'h6835_0000 | 32'h0000_006F, 6'b0);
    // seed old status, then R10 start with clear in same write
    step(0, 0, 6'b001000);
    step(0, 0, 6'b000100);
    step(1, 32'h8000_0F00 | 32'h0000_0008, 6'b0);
    chk("R10 status cleared by start write", {26'b0, stat_of(rd_data)}, 32'd0);
    chk("R10 start strobe", {31'b0, start_stb}, 32'd1);
    step(0, 0, 0);
    // GO while active ignored (R2), config write while active ignored (R5)
    step(1, 32'h8877_0008, 6'b0);
    // stop while active (R4)
    step(1, 32'h4000_0008, 6'b0);
    // done ends it (R6), irq via enable (R9)
    step(0, 0, 6'b001000);
    chk("R9 irq from done", {31'b0, irq}, 32'd1);
    // event and its clear in same cycle: set wins (R7)
    step(1, 32'h0000_0808, 6'b001000);
    chk("R7 set beats clear", {31'b0, rd_data[11]}, 32'd1);
    step(1, 32'h0000_0800, 6'b0);
    chk("R9 irq after ack", {31'b0, irq}, 32'd0);
    // halt while active, event in same cycle gives no strobe (R4)
    step(1, 32'h8000_0000, 6'b0);
    step(1, 32'h2000_0000, 6'b010000);
    step(1, 32'h2000_0000, 6'b0);

    // random phase
    for (int n = 0; n < 1500; n++) begin
      d = $urandom();
      if (($urandom() % 3) == 0) d[31] = 1'b1;
      e = 6'b0;
      if (($urandom() % 6) == 0) e[$urandom() % 6] = 1'b1;
      step(($urandom() % 4) == 0, d, e);
    end

    @(negedge clk);
    wr_en = 1'b0; ev = '0;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule